// File: doc/BRIEF.md
# Predicated Element Issue Sequencer

This block expands one operation, encoded with scalar register numbers, into the element operations it stands for over a vector length. It accepts a destination and two source register numbers, a flag per operand saying whether that operand steps through consecutive registers, a vector length, an element mask and a zeroing flag. It then hands the element operations to an ALU that takes up to `LANES` elements per beat.

In skip mode, elements whose mask bit is clear are dropped, and the surviving elements are packed down into the lowest lanes. In zeroing mode, every element below the vector length is issued, and those with a clear mask bit are flagged as zero-writes. When no operand is vectorised, exactly one plain operation leaves the block.

The ALU side uses a valid/ready handshake. A beat stays unchanged until it is accepted. A one-cycle `done` pulse marks the end of every operation, including operations that issue nothing.

Top module: `elem_issue_seq`

## Requirements
- R1: `op_ready` is 1 only while no operation is in progress; an operation is taken on a clock edge where `op_valid` and `op_ready` are both 1, and `op_ready` and `lane_valid` are never 1 together.
- R2: Only elements with index i < min(`vl`, VL_MAX) are issued; across the enabled lanes of a beat, and from one beat to the next, element indices strictly ascend.
- R3: In skip mode (`zero_mode`=0), elements with mask bit i set are packed into lanes 0,1,2,... in ascending order, at most LANES per beat, so n active elements take ceil(n/LANES) beats; enabled lanes always form a run that starts at lane 0.
- R4: In zeroing mode (`zero_mode`=1), every element below the vector length is issued; an element's `lane_zero` bit is 1 exactly when its mask bit is 0, and `lane_zero` is never set on a disabled lane.
- R5: For element i, the physical destination index is (`rd` + i) mod 2^REGW when `rd_vec`=1 and `rd` otherwise; `rs1` and `rs2` follow the same rule, each with its own flag.
- R6: When `rd_vec`, `rs1_vec` and `rs2_vec` are all 0, exactly one beat is issued, with lane 0 only, element 0, the unmodified register numbers and `lane_zero`=0, whatever `vl`, `mask` and `zero_mode` are (including `vl`=0).
- R7: While `lane_valid`=1 and `lane_ready`=0, `lane_valid` stays 1 and all lane fields hold their values on the next cycle.
- R8: An operation with `vl`=0, or in skip mode with no mask bit set below `vl`, issues no beat, and `done` is 1 in the cycle after it is accepted.
- R9: `done` is 1 for one cycle right after the edge that accepts the final beat; in that cycle `op_ready` is 1 and `lane_valid` is 0.
- R10: After reset, `op_ready`=1, `lane_valid`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Sequencer idle; it can take an operation |
| rd | input | REGW | Destination register number |
| rs1 | input | REGW | First source register number |
| rs2 | input | REGW | Second source register number |
| rd_vec | input | 1 | Destination steps per element |
| rs1_vec | input | 1 | First source steps per element |
| rs2_vec | input | 1 | Second source steps per element |
| vl | input | $clog2(VL_MAX+1) | Vector length |
| mask | input | VL_MAX | Element enable mask, bit i for element i |
| zero_mode | input | 1 | 1: masked elements become zero-writes; 0: they are skipped |
| lane_valid | output | 1 | Beat offered to the ALU |
| lane_ready | input | 1 | ALU takes the beat |
| lane_en | output | LANES | Per-lane enable |
| lane_elem | output | LANES*EW | Element index per lane |
| lane_rd | output | LANES*REGW | Physical destination index per lane |
| lane_rs1 | output | LANES*REGW | Physical first source index per lane |
| lane_rs2 | output | LANES*REGW | Physical second source index per lane |
| lane_zero | output | LANES | Per-lane zero-write flag |
| done | output | 1 | One-cycle pulse when an operation finishes |

## Verification
The bench runs every 8-bit mask against every combination of the three vectorised flags, in both modes. For each pair it uses a full vector length and a shorter, varying one, which also covers zero and lengths beyond the maximum. The full-length runs with dense, sparse and empty masks separate correct packing and beat counts in skip mode from the zero-write marking in zeroing mode. The short lengths show that bits past the length are never issued. The flag combinations separate each operand's offset stepping from the others. The all-zero flag case shows the single plain issue overriding mask, length and mode. Register bases near the top of the index space check wrap-around. Stalled beats show that the lane outputs are held.

// File: rtl/esq_pkg.sv
package esq_pkg;
    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_BUSY = 1'b1
    } sq_state_e;
endpackage

// File: rtl/esq_lane_picker.sv
// Selects the lowest LANES set bits of the pending vector and packs their indices into lanes.
module esq_lane_picker #(
    parameter int VL_MAX = 8,
    parameter int LANES  = 4,
    parameter int EW     = 3
) (
    input  logic [VL_MAX-1:0]   pend,
    output logic [LANES-1:0]    en,
    output logic [LANES*EW-1:0] elem,
    output logic [VL_MAX-1:0]   taken
);
    always_comb begin
        int unsigned cnt;
        cnt   = 0;
        en    = '0;
        elem  = '0;
        taken = '0;
        for (int i = 0; i < VL_MAX; i++) begin
            if (pend[i] && (cnt < LANES)) begin
                en[cnt]             = 1'b1;
                elem[cnt*EW +: EW]  = EW'(i);
                taken[i]            = 1'b1;
                cnt                 = cnt + 1;
            end
        end
    end
endmodule

// File: rtl/esq_reg_offset.sv
// Physical register index: the base, stepped by the element number when the operand is vectorised.
module esq_reg_offset #(
    parameter int REGW = 5,
    parameter int EW   = 3
) (
    input  logic [REGW-1:0] base,
    input  logic            step,
    input  logic [EW-1:0]   elem,
    output logic [REGW-1:0] phys
);
    always_comb begin
        if (step) phys = base + REGW'(elem);
        else      phys = base;
    end
endmodule

// File: rtl/elem_issue_seq.sv
module elem_issue_seq #(
    parameter int VL_MAX = 8,
    parameter int LANES  = 4,
    parameter int REGW   = 5
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               op_valid,
    output logic                               op_ready,
    input  logic [REGW-1:0]                    rd,
    input  logic [REGW-1:0]                    rs1,
    input  logic [REGW-1:0]                    rs2,
    input  logic                               rd_vec,
    input  logic                               rs1_vec,
    input  logic                               rs2_vec,
    input  logic [$clog2(VL_MAX+1)-1:0]        vl,
    input  logic [VL_MAX-1:0]                  mask,
    input  logic                               zero_mode,
    output logic                               lane_valid,
    input  logic                               lane_ready,
    output logic [LANES-1:0]                   lane_en,
    output logic [LANES*((VL_MAX>1)?$clog2(VL_MAX):1)-1:0] lane_elem,
    output logic [LANES*REGW-1:0]              lane_rd,
    output logic [LANES*REGW-1:0]              lane_rs1,
    output logic [LANES*REGW-1:0]              lane_rs2,
    output logic [LANES-1:0]                   lane_zero,
    output logic                               done
);
    import esq_pkg::*;

    localparam int EW = (VL_MAX > 1) ? $clog2(VL_MAX) : 1;
    localparam int CW = $clog2(VL_MAX + 1);

    typedef struct packed {
        sq_state_e         st;
        logic [VL_MAX-1:0] pend;
        logic [VL_MAX-1:0] msk;
        logic              zmode;
        logic              scalar;
        logic [REGW-1:0]   rd;
        logic [REGW-1:0]   rs1;
        logic [REGW-1:0]   rs2;
        logic              rdv;
        logic              r1v;
        logic              r2v;
        logic              done;
    } seq_state_t;

    seq_state_t s_d, s_q;

    logic [VL_MAX-1:0] len_mask;
    logic [VL_MAX-1:0] taken;
    logic [LANES-1:0]  pick_en;

    // Elements below the requested length (clamped at VL_MAX).
    always_comb begin
        for (int i = 0; i < VL_MAX; i++) begin
            len_mask[i] = (i < int'(vl));
        end
    end

    esq_lane_picker #(
        .VL_MAX(VL_MAX),
        .LANES (LANES),
        .EW    (EW)
    ) u_pick (
        .pend (s_q.pend),
        .en   (pick_en),
        .elem (lane_elem),
        .taken(taken)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [EW-1:0] e_k;
        assign e_k = lane_elem[k*EW +: EW];

        esq_reg_offset #(.REGW(REGW), .EW(EW)) u_rd (
            .base(s_q.rd), .step(s_q.rdv), .elem(e_k), .phys(lane_rd[k*REGW +: REGW])
        );
        esq_reg_offset #(.REGW(REGW), .EW(EW)) u_rs1 (
            .base(s_q.rs1), .step(s_q.r1v), .elem(e_k), .phys(lane_rs1[k*REGW +: REGW])
        );
        esq_reg_offset #(.REGW(REGW), .EW(EW)) u_rs2 (
            .base(s_q.rs2), .step(s_q.r2v), .elem(e_k), .phys(lane_rs2[k*REGW +: REGW])
        );

        assign lane_zero[k] = pick_en[k] & s_q.zmode & ~s_q.scalar & ~s_q.msk[e_k];
    end

    assign lane_en    = pick_en;
    assign lane_valid = (s_q.st == SQ_BUSY);
    assign op_ready   = (s_q.st == SQ_IDLE);
    assign done       = s_q.done;

    always_comb begin
        logic [VL_MAX-1:0] rem;
        logic              all_scalar;
        s_d        = s_q;
        s_d.done   = 1'b0;
        rem        = s_q.pend & ~taken;
        all_scalar = ~(rd_vec | rs1_vec | rs2_vec);

        if (s_q.st == SQ_IDLE) begin
            if (op_valid) begin
                s_d.rd     = rd;
                s_d.rs1    = rs1;
                s_d.rs2    = rs2;
                s_d.rdv    = rd_vec;
                s_d.r1v    = rs1_vec;
                s_d.r2v    = rs2_vec;
                s_d.msk    = mask;
                s_d.zmode  = zero_mode;
                s_d.scalar = all_scalar;
                if (all_scalar)     s_d.pend = VL_MAX'(1);
                else if (zero_mode) s_d.pend = len_mask;
                else                s_d.pend = mask & len_mask;

                if (s_d.pend == '0) s_d.done = 1'b1;
                else                s_d.st   = SQ_BUSY;
            end
        end else if (lane_ready) begin
            s_d.pend = rem;
            if (rem == '0) begin
                s_d.st   = SQ_IDLE;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/esq_checker.sv
module esq_checker #(
    parameter int LANES = 4,
    parameter int EW    = 3,
    parameter int REGW  = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   op_ready,
    input logic                   lane_valid,
    input logic                   lane_ready,
    input logic [LANES-1:0]       lane_en,
    input logic [LANES*EW-1:0]    lane_elem,
    input logic [LANES*REGW-1:0]  lane_rd,
    input logic [LANES-1:0]       lane_zero,
    input logic                   done
);
    p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_ready && lane_valid));

    p_first_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lane_valid |-> lane_en[0]);

    p_zero_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_zero & ~lane_en) == '0);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_valid && !lane_ready) |=> (lane_valid && $stable(lane_en) &&
            $stable(lane_elem) && $stable(lane_rd) && $stable(lane_zero)));

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (op_ready && !lane_valid));

    for (genvar k = 1; k < LANES; k++) begin : g_asc
        p_ascend_r2: assert property (@(posedge clk) disable iff (!rst_n)
            lane_en[k] |-> (lane_en[k-1] &&
                (lane_elem[k*EW +: EW] > lane_elem[(k-1)*EW +: EW])));
    end
endmodule

bind elem_issue_seq esq_checker #(
    .LANES(LANES),
    .EW   (EW),
    .REGW (REGW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_ready  (op_ready),
    .lane_valid(lane_valid),
    .lane_ready(lane_ready),
    .lane_en   (lane_en),
    .lane_elem (lane_elem),
    .lane_rd   (lane_rd),
    .lane_zero (lane_zero),
    .done      (done)
);

// File: tb/elem_issue_seq_test.sv
module elem_issue_seq_test;
    localparam int VLM = 8;
    localparam int L   = 4;
    localparam int RW  = 5;
    localparam int EW  = 3;
    localparam int CW  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_valid = 1'b0;
    logic op_ready;
    logic [RW-1:0] rd = '0, rs1 = '0, rs2 = '0;
    logic rd_vec = 1'b0, rs1_vec = 1'b0, rs2_vec = 1'b0;
    logic [CW-1:0] vl = '0;
    logic [VLM-1:0] mask = '0;
    logic zero_mode = 1'b0;
    logic lane_valid;
    logic lane_ready = 1'b0;
    logic [L-1:0] lane_en, lane_zero;
    logic [L*EW-1:0] lane_elem;
    logic [L*RW-1:0] lane_rd, lane_rs1, lane_rs2;
    logic done;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    elem_issue_seq #(.VL_MAX(VLM), .LANES(L), .REGW(RW)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .rd(rd), .rs1(rs1), .rs2(rs2), .rd_vec(rd_vec), .rs1_vec(rs1_vec),
        .rs2_vec(rs2_vec), .vl(vl), .mask(mask), .zero_mode(zero_mode),
        .lane_valid(lane_valid), .lane_ready(lane_ready), .lane_en(lane_en),
        .lane_elem(lane_elem), .lane_rd(lane_rd), .lane_rs1(lane_rs1),
        .lane_rs2(lane_rs2), .lane_zero(lane_zero), .done(done)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [RW-1:0] rd_i, input logic [RW-1:0] r1_i,
                          input logic [RW-1:0] r2_i, input logic [2:0] vecs,
                          input logic [CW-1:0] vl_i, input logic [VLM-1:0] m,
                          input logic z, input bit stall);
        int n;
        int ee[VLM];
        bit ez[VLM];
        int lim;
        bit scal;
        string tag;
        n = 0;
        scal = (vecs == 3'b000);
        lim = (int'(vl_i) > VLM) ? VLM : int'(vl_i);
        if (scal) begin
            ee[0] = 0; ez[0] = 1'b0; n = 1;
        end else begin
            for (int i = 0; i < lim; i++) begin
                if (m[i]) begin
                    ee[n] = i; ez[n] = 1'b0; n++;
                end else if (z) begin
                    ee[n] = i; ez[n] = 1'b1; n++;
                end
            end
        end
        tag = scal ? "R6" : (z ? "R4" : "R3");

        @(negedge clk);
        chk(op_ready == 1'b1, "R1", {63'd0, op_ready}, 64'd1);
        rd = rd_i; rs1 = r1_i; rs2 = r2_i;
        {rd_vec, rs1_vec, rs2_vec} = vecs;
        vl = vl_i; mask = m; zero_mode = z; op_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;

        if (n == 0) begin
            // R8: nothing issued, done right after acceptance
            chk(!lane_valid && done, "R8", {62'd0, lane_valid, done}, 64'd1);
        end else begin
            for (int b = 0; b * L < n; b++) begin
                logic [L-1:0] exp_en;
                logic [L*EW-1:0] h_elem;
                logic [L-1:0] h_en;
                logic [L*RW-1:0] h_rd;
                chk(lane_valid && !op_ready, "R1", {62'd0, lane_valid, op_ready}, 64'd2);
                if (stall) begin
                    lane_ready = 1'b0;
                    h_elem = lane_elem; h_en = lane_en; h_rd = lane_rd;
                    @(negedge clk);
                    chk(lane_valid && lane_elem == h_elem && lane_en == h_en && lane_rd == h_rd,
                        "R7", {31'd0, lane_valid, lane_en, lane_elem, lane_rd},
                        {31'd0, 1'b1, h_en, h_elem, h_rd});
                end
                for (int k = 0; k < L; k++) exp_en[k] = (b * L + k) < n;
                chk(lane_en == exp_en, tag, 64'(lane_en), 64'(exp_en));
                for (int k = 0; k < L; k++) begin
                    if (exp_en[k]) begin
                        int e;
                        logic [RW-1:0] xd, x1, x2;
                        logic [EW+3*RW:0] act, exp;
                        e = ee[b * L + k];
                        xd = vecs[2] ? RW'(int'(rd_i) + e) : rd_i;
                        x1 = vecs[1] ? RW'(int'(r1_i) + e) : r1_i;
                        x2 = vecs[0] ? RW'(int'(r2_i) + e) : r2_i;
                        exp = {EW'(e), xd, x1, x2, ez[b * L + k]};
                        act = {lane_elem[k*EW +: EW], lane_rd[k*RW +: RW],
                               lane_rs1[k*RW +: RW], lane_rs2[k*RW +: RW], lane_zero[k]};
                        // R2 ordering, R5 offsets, plus the mode tag
                        chk(act == exp, (tag == "R6") ? "R6" : "R2,R5,R4", 64'(act), 64'(exp));
                    end
                end
                lane_ready = 1'b1;
                @(posedge clk);
                @(negedge clk);
                lane_ready = 1'b0;
            end
            chk(done && op_ready && !lane_valid, "R9",
                {61'd0, done, op_ready, lane_valid}, 64'b110);
        end
        @(negedge clk);
        chk(!done, "R9", {63'd0, done}, 64'd0);
    endtask

    initial begin
        #1;
        chk(op_ready && !lane_valid && !done, "R10",
            {61'd0, op_ready, lane_valid, done}, 64'b100);
        #22;
        rst_n = 1'b1;
        @(negedge clk);
        chk(op_ready && !lane_valid && !done, "R10",
            {61'd0, op_ready, lane_valid, done}, 64'b100);

        // Six of eight enabled: 2 beats on 4 lanes (R3)
        run_op(5'd4, 5'd10, 5'd20, 3'b111, 4'd8, 8'b1101_1011, 1'b0, 1'b0);
        // Empty cases (R8)
        run_op(5'd1, 5'd2, 5'd3, 3'b100, 4'd0, 8'hFF, 1'b1, 1'b0);
        run_op(5'd1, 5'd2, 5'd3, 3'b010, 4'd8, 8'h00, 1'b0, 1'b0);
        // Scalar with vl=0 still issues once (R6)
        run_op(5'd7, 5'd8, 5'd9, 3'b000, 4'd0, 8'h00, 1'b1, 1'b1);

        for (int m = 0; m < 256; m++) begin
            for (int z = 0; z < 2; z++) begin
                for (int vc = 0; vc < 8; vc++) begin
                    for (int s = 0; s < 2; s++) begin
                        logic [CW-1:0] vli;
                        vli = (s == 0) ? 4'd8 : CW'((m * 7 + vc * 3 + z) % 11);
                        run_op(RW'(m + 27), RW'(m * 3), RW'(31 - m), 3'(vc), vli,
                               8'(m), z[0], ((m + vc + s) % 5) == 0);
                    end
                end
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule